// File: doc/BRIEF.md
# Dual-Clock FIFO with Narrow-Read Bus Matching

This block moves 36-bit long words from one clock domain to another through a 64-entry store. The writer works on `clk_a` and pushes one long word per accepted write. The reader works on `clk_b` and can take each long word whole, as two 18-bit halves or as four 9-bit bytes. The `rd_size` input picks the width. A long word counts as stored until its last piece has been read. All four status flags therefore count whole long words.

Write and read pointers cross between the clocks as Gray codes through two-flop synchronizers. The write domain derives `full` and `almost_full` from the synchronized read pointer. The read domain derives `empty` and `almost_empty` from the synchronized write pointer.

The output is first-word-fall-through. While `empty` is low, `rd_data` shows the current piece of the head long word, right-aligned with zeros above it. A read with `rd_en` high consumes that piece on the next `clk_b` edge. A single active-low asynchronous reset `rst_n` clears both domains.

Top module: `dcfifo_narrow_rd`

## Requirements
- R1: Long words leave in the order they were written, with all 36 bits intact, when `rd_size` is 0.
- R2: A write is accepted on a rising `clk_a` edge only when `cs_n` is 0, `dir_wr` is 1, `wr_en` is 1 and `full` is 0. Any other write attempt leaves the contents and the flags unchanged.
- R3: The `rd_size` encoding is as follows.
  - 0 and 3: each read returns the whole 36-bit long word.
  - 1: two reads per long word. Bits [35:18] come first, then bits [17:0], each placed on `rd_data[17:0]`.
  - 2: four reads per long word. Bits [35:27] come first, then [26:18], [17:9] and [8:0], each placed on `rd_data[8:0]`.
- R4: Occupancy drops only on the read that takes the last piece of a long word. A full FIFO stays full after a partial read.
- R5: When `rd_size` differs from its value at the previous `clk_b` edge, the piece position returns to the first (most significant) piece.
- R6: `full` is high exactly when 64 long words are held. It is synchronous to `clk_a` and low after reset.
- R7: `empty` is high when no long word is held, and is high after reset. After a write into an empty FIFO, `empty` falls on the second rising `clk_b` edge following that write's `clk_a` edge.
- R8: `almost_empty` is high when X or fewer long words are held (X = `AE_AF_OFFSET`, default 8).
- R9: `almost_full` is high when 64−X or more long words are held.
- R10: A read while `empty` is high is ignored. It does not advance the read position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| cs_n | input | 1 | Active-low chip select for the write port |
| dir_wr | input | 1 | Direction, 1 selects write |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Long word to store |
| full | output | 1 | FIFO holds 64 long words (clk_a) |
| almost_full | output | 1 | FIFO holds 64−X or more long words (clk_a) |
| rd_en | input | 1 | Read enable, consumes the current piece |
| rd_size | input | 2 | Read width: 0/3 = 36, 1 = 18, 2 = 9 bits |
| rd_data | output | 36 | Current piece of the head long word, right-aligned |
| empty | output | 1 | FIFO holds no long word (clk_b) |
| almost_empty | output | 1 | FIFO holds X or fewer long words (clk_b) |

## Verification
The assertions assume the following about the inputs:
- `rd_size` and the read enable are driven synchronously to `clk_b`.
- The write controls are driven synchronously to `clk_a`.
- `rst_n` is low from time zero until both clocks have run.

The bench respects these by changing write inputs only on falling `clk_a` edges and read inputs only on falling `clk_b` edges. The two clocks run at the same rate with a fixed phase offset, so the empty-release latency is deterministic and can be checked cycle-exactly. Every other flag is checked only after both synchronizers have had several cycles to settle.

// File: rtl/dcfifo_narrow_rd.sv
module dcfifo_narrow_rd #(
  parameter int DW = 36,
  parameter int AW = 6,
  parameter int AE_AF_OFFSET = 8
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          dir_wr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rd_en,
  input  logic [1:0]    rd_size,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;
  localparam int HW = DW / 2;
  localparam int QW = DW / 4;
  localparam logic [PW-1:0] AF_LVL = PW'(DEPTH - AE_AF_OFFSET);
  localparam logic [PW-1:0] AE_LVL = PW'(AE_AF_OFFSET);

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    for (int i = 0; i < PW; i++) b[i] = ^(g >> i);
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, rbin, wgray, rgray;
  logic [PW-1:0] rg_s1, rg_s2, wg_s1, wg_s2;
  logic [1:0]    piece, size_q;

  wire [PW-1:0] wcnt = wbin - g2b(rg_s2);
  wire [PW-1:0] rcnt = g2b(wg_s2) - rbin;

  assign full         = wcnt[AW];
  assign almost_full  = wcnt >= AF_LVL;
  assign empty        = rcnt == '0;
  assign almost_empty = rcnt <= AE_LVL;

  wire wr_fire = !cs_n && dir_wr && wr_en && !full;

  always_ff @(posedge clk_a or negedge rst_n)
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rg_s1 <= '0;
      rg_s2 <= '0;
    end else begin
      rg_s1 <= rgray;
      rg_s2 <= rg_s1;
      if (wr_fire) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end

  always_ff @(posedge clk_a)
    if (wr_fire) mem[wbin[AW-1:0]] <= wr_data;

  wire       size_chg  = rd_size != size_q;
  wire [1:0] piece_cur = size_chg ? 2'd0 : piece;
  wire [1:0] last_pc   = (rd_size == 2'd1) ? 2'd1 : (rd_size == 2'd2) ? 2'd3 : 2'd0;
  wire       rd_fire   = rd_en && !empty;
  wire       pop       = rd_fire && (piece_cur == last_pc);
  wire [DW-1:0] head   = mem[rbin[AW-1:0]];

  always_comb begin
    rd_data = '0;
    case (rd_size)
      2'd1:    rd_data[HW-1:0] = piece_cur[0] ? head[HW-1:0] : head[DW-1:HW];
      2'd2:    rd_data[QW-1:0] = head[DW-1-QW*piece_cur -: QW];
      default: rd_data = head;
    endcase
  end

  always_ff @(posedge clk_b or negedge rst_n)
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      wg_s1  <= '0;
      wg_s2  <= '0;
      piece  <= '0;
      size_q <= '0;
    end else begin
      wg_s1  <= wgray;
      wg_s2  <= wg_s1;
      size_q <= rd_size;
      if (pop) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
        piece <= '0;
      end else if (rd_fire) begin
        piece <= piece_cur + 1'b1;
      end else begin
        piece <= piece_cur;
      end
    end
endmodule

module dcfifo_narrow_rd_chk #(
  parameter int PW = 7
) (
  input logic          clk_a,
  input logic          clk_b,
  input logic          rst_n,
  input logic          cs_n,
  input logic          dir_wr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [1:0]    rd_size,
  input logic          full,
  input logic          almost_full,
  input logic          empty,
  input logic          almost_empty,
  input logic [PW-1:0] wbin,
  input logic [PW-1:0] rbin,
  input logic [1:0]    piece,
  input logic [1:0]    size_q
);
  p_no_write_when_full_r2: assert property (@(posedge clk_a) disable iff (!rst_n)
    (full && !cs_n && dir_wr && wr_en) |=> $stable(wbin));

  p_no_read_when_empty_r10: assert property (@(posedge clk_b) disable iff (!rst_n)
    (empty && rd_en) |=> ($stable(rbin) && $stable(piece)));

  p_half_read_keeps_word_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
    (rd_en && !empty && rd_size == 2'd1 && size_q == 2'd1 && piece == 2'd0) |=> $stable(rbin));

  p_size_change_restarts_r5: assert property (@(posedge clk_b) disable iff (!rst_n)
    (rd_size != size_q && !(rd_en && !empty)) |=> (piece == 2'd0));

  p_full_implies_af_r9: assert property (@(posedge clk_a) disable iff (!rst_n)
    full |-> almost_full);

  p_empty_implies_ae_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
    empty |-> almost_empty);
endmodule

bind dcfifo_narrow_rd dcfifo_narrow_rd_chk #(.PW(PW)) u_chk (
  .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .cs_n(cs_n), .dir_wr(dir_wr),
  .wr_en(wr_en), .rd_en(rd_en), .rd_size(rd_size), .full(full),
  .almost_full(almost_full), .empty(empty), .almost_empty(almost_empty),
  .wbin(wbin), .rbin(rbin), .piece(piece), .size_q(size_q)
);

// File: tb/dcfifo_narrow_rd_tb.sv
module dcfifo_narrow_rd_tb;
  localparam int X = 8;
  localparam int N = 64;

  logic clk_a = 0, clk_b = 0, rst_n = 0;
  logic cs_n = 1, dir_wr = 0, wr_en = 0, rd_en = 0;
  logic [1:0] rd_size = 0;
  logic [35:0] wr_data = 0, rd_data;
  logic full, almost_full, empty, almost_empty;
  int checks = 0, fails = 0;

  always #4 clk_a = ~clk_a;
  initial begin #1; forever #4 clk_b = ~clk_b; end

  dcfifo_narrow_rd u_dut (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .cs_n(cs_n), .dir_wr(dir_wr),
    .wr_en(wr_en), .wr_data(wr_data), .full(full), .almost_full(almost_full),
    .rd_en(rd_en), .rd_size(rd_size), .rd_data(rd_data), .empty(empty),
    .almost_empty(almost_empty)
  );

  function automatic logic [35:0] pat(input int k);
    logic [35:0] t = 36'(k);
    return (t * 36'h013579BDF) ^ 36'h5A5A5A5A5;
  endfunction

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk_b);
  endtask

  task automatic check_flags(input int n);
    check("R6 full", 36'(full), 36'(n == N));
    check("R7 empty", 36'(empty), 36'(n == 0));
    check("R8 almost_empty", 36'(almost_empty), 36'(n <= X));
    check("R9 almost_full", 36'(almost_full), 36'(n >= N - X));
  endtask

  task automatic do_write(input logic [35:0] d, input logic cs, input logic dir);
    @(negedge clk_a);
    wr_data = d; cs_n = cs; dir_wr = dir; wr_en = 1;
    @(negedge clk_a);
    wr_en = 0; cs_n = 1; dir_wr = 0;
  endtask

  task automatic read_check(input string tag, input logic [35:0] exp);
    @(negedge clk_b);
    check(tag, rd_data, exp);
    rd_en = 1;
    @(negedge clk_b);
    rd_en = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_a);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_a);
    rst_n = 1;
    settle();
    check_flags(0);

    // R2: disqualified writes
    do_write(pat(100), 1'b1, 1'b1);
    do_write(pat(101), 1'b0, 1'b0);
    settle();
    check("R2 ignored write", 36'(empty), 36'd1);

    // R10: read while empty
    @(negedge clk_b); rd_en = 1;
    @(negedge clk_b); rd_en = 0;
    settle();

    // fill sweep
    for (int i = 0; i < N; i++) begin
      if (i == 0) begin
        @(negedge clk_a);
        wr_data = pat(0); cs_n = 0; dir_wr = 1; wr_en = 1;
        @(posedge clk_a);
        @(negedge clk_a);
        wr_en = 0; cs_n = 1; dir_wr = 0;
        @(negedge clk_b);
        check("R7 empty after 1 b edge", 36'(empty), 36'd1);
        @(negedge clk_b);
        check("R7 empty after 2 b edges", 36'(empty), 36'd0);
      end else begin
        do_write(pat(i), 1'b0, 1'b1);
      end
      settle();
      check_flags(i + 1);
    end

    // R2/R6: write while full
    do_write(pat(200), 1'b0, 1'b1);
    settle();
    check_flags(N);

    // R3/R4: halves
    rd_size = 2'd1;
    read_check("R1/R10 head after empty read, R3 upper half", {18'd0, pat(0)[35:18]});
    settle();
    check("R4 full after partial read", 36'(full), 36'd1);
    read_check("R3 lower half", {18'd0, pat(0)[17:0]});
    settle();
    check_flags(N - 1);

    // R3 bytes then R5 size change
    rd_size = 2'd2;
    read_check("R3 byte 0", {27'd0, pat(1)[35:27]});
    read_check("R3 byte 1", {27'd0, pat(1)[26:18]});
    settle();
    check_flags(N - 1);
    rd_size = 2'd1;
    read_check("R5 restart at upper half", {18'd0, pat(1)[35:18]});
    read_check("R5 lower half", {18'd0, pat(1)[17:0]});
    settle();
    check_flags(N - 2);

    // R1: drain at full width
    rd_size = 2'd0;
    for (int k = 2; k < N; k++) begin
      read_check("R1 long word order", pat(k));
      settle();
      check_flags(N - 1 - k);
    end

    // R3 code 3 as full width; also shows the full-time write was dropped (R2)
    rd_size = 2'd3;
    do_write(pat(300), 1'b0, 1'b1);
    settle();
    check_flags(1);
    read_check("R3 size code 3", pat(300));
    settle();
    check_flags(0);

    // four bytes of one word
    rd_size = 2'd2;
    do_write(pat(301), 1'b0, 1'b1);
    settle();
    read_check("R3 byte 0", {27'd0, pat(301)[35:27]});
    read_check("R3 byte 1", {27'd0, pat(301)[26:18]});
    read_check("R3 byte 2", {27'd0, pat(301)[17:9]});
    settle();
    check("R4 word held before last byte", 36'(empty), 36'd0);
    read_check("R3 byte 3", {27'd0, pat(301)[8:0]});
    settle();
    check_flags(0);

    finish_run();
  end
endmodule